// File: doc/BRIEF.md
# Banked Memory with Divided Word Lines

This block is a synthesizable behavioural model of a static memory that is split into several banks. Each bank's rows are cut into column groups, and every group has its own local word line. An access drives only the bank that holds the addressed word. Inside that bank it drives only the local word line of the group that holds the word. All other banks and groups stay quiet. This gating is what keeps the switched capacitance of each access down.

A requester presents a valid strobe, a read/write flag, an address and write data. The address is split into a bank index, a row index and a group index. A write updates the single addressed word. A read returns the word, with a one-cycle valid pulse, on the cycle after the request. The block also exposes the one-hot bank and group enable vectors and a per-bank access counter. With these, a testbench can confirm from outside that idle banks and groups record no activity. Cells, precharge and sense circuits are not modelled.

Top module: `banked_sram`

## Requirements
- R1: While `req_valid` is high, `bank_en` has exactly one bit set: the bit of the bank index taken from the address. While `req_valid` is low, `bank_en` is all zero.
- R2: While `req_valid` is high, `grp_en` has exactly one bit set: the bit of the group index taken from the address. While `req_valid` is low, `grp_en` is all zero.
- R3: The address is read from most to least significant bit as bank index, then row index, then group index. With defaults (4 banks, 8 rows, 4 groups), bank is `req_addr[6:5]`, row is `req_addr[4:2]` and group is `req_addr[1:0]`.
- R4: A write changes only the addressed word. Every other word in every bank keeps its value.
- R5: A read request sets `rd_valid` high for one cycle on the following clock edge. On that cycle `rd_data` holds the addressed word, including a word written on the immediately preceding cycle.
- R6: After a write request or an idle cycle, `rd_valid` is low and `rd_data` keeps its previous value.
- R7: On each valid access, the counter of the addressed bank (field b of `bank_cnt`, bits `[b*CNT_W +: CNT_W]`) increases by one. The counters of all other banks do not change, and no counter changes on an idle cycle.
- R8: While `rst_n` is low at a clock edge, every stored word, every counter, `rd_data` and `rd_valid` is cleared. A read of a word that has not been written since reset returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (7) | Word address: bank, row, group fields |
| req_wdata | input | WIDTH (8) | Write data |
| rd_data | output | WIDTH (8) | Read data, registered |
| rd_valid | output | 1 | High for one cycle after a read request |
| bank_en | output | BANKS (4) | One-hot bank enable of the current access |
| grp_en | output | GROUPS (4) | One-hot local word-line group enable of the current access |
| bank_cnt | output | BANKS*CNT_W (64) | Packed per-bank access counters |

## Verification
A wrong address split or a faulty decoder shows on `bank_en` or `grp_en` in the same cycle as the request. Because these are combinational, the error is visible before the clock edge. A local word line gated onto the wrong row or group corrupts a word that was not addressed. That corruption stays hidden until the word is read back, so the bench writes every address and then reads every address. A counter stepping in the wrong bank shows one cycle after the access that caused it.

// File: rtl/bsram_pkg.sv
// Package: shared types for the banked memory.
// Assumes: nothing; holds only the access-kind encoding.
package bsram_pkg;
    typedef enum logic {
        ACC_READ  = 1'b0,
        ACC_WRITE = 1'b1
    } acc_op_e;
endpackage

// File: rtl/bsram_decode.sv
// Module: address decoder. Splits the address into bank, row and group
// fields (MSB to LSB) and produces one-hot selects gated by the request.
// Assumes: BANKS, ROWS and GROUPS are powers of two, each at least 2.
module bsram_decode #(
    parameter int BANKS  = 4,
    parameter int ROWS   = 8,
    parameter int GROUPS = 4,
    localparam int BANK_W = $clog2(BANKS),
    localparam int ROW_W  = $clog2(ROWS),
    localparam int GRP_W  = $clog2(GROUPS),
    localparam int ADDR_W = BANK_W + ROW_W + GRP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] bank_idx,
    output logic [ROW_W-1:0]  row_idx,
    output logic [GRP_W-1:0]  grp_idx,
    output logic [BANKS-1:0]  bank_oh,
    output logic [ROWS-1:0]   row_oh,
    output logic [GROUPS-1:0] grp_oh
);
    // Field split: bank on top, group at the bottom.
    assign bank_idx = addr[ADDR_W-1 -: BANK_W];
    assign row_idx  = addr[GRP_W +: ROW_W];
    assign grp_idx  = addr[GRP_W-1:0];

    // One-hot expansion of each field, all zero while no request is present.
    always_comb begin
        bank_oh = '0;
        row_oh  = '0;
        grp_oh  = '0;
        if (valid) begin
            bank_oh[bank_idx] = 1'b1;
            row_oh[row_idx]   = 1'b1;
            grp_oh[grp_idx]   = 1'b1;
        end
    end

    // R1: exactly one bank per valid request, none when idle
    p_bank_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> ($countones(bank_oh) == 1));
    p_bank_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (bank_oh == '0));
    // R2: exactly one group per valid request, none when idle
    p_grp_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> ($countones(grp_oh) == 1));
endmodule

// File: rtl/bsram_bank.sv
// Module: one memory bank. Each column group has a local word line per row,
// formed by gating the global row select with the group select.
// Writes go only through the active local word line.
// Assumes: row_oh is one-hot or zero; sel gates all local activity.
module bsram_bank #(
    parameter int ROWS   = 8,
    parameter int GROUPS = 4,
    parameter int WIDTH  = 8,
    localparam int ROW_W = $clog2(ROWS),
    localparam int GRP_W = $clog2(GROUPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [ROWS-1:0]   row_oh,
    input  logic [GROUPS-1:0] grp_oh,
    input  logic [ROW_W-1:0]  row_idx,
    input  logic [GRP_W-1:0]  grp_idx,
    input  logic [WIDTH-1:0]  wdata,
    output logic [WIDTH-1:0]  rd_word,
    output logic [GROUPS-1:0] grp_en
);
    logic [WIDTH-1:0] group_word [GROUPS];

    // Group enables exist only inside the selected bank.
    assign grp_en = sel ? grp_oh : '0;

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        logic [ROWS-1:0]  lwl;
        logic [WIDTH-1:0] cells [ROWS];

        // Local word line gate: global row select AND group enable.
        assign lwl = row_oh & {ROWS{grp_en[g]}};

        // Storage of this group: cleared on reset, written via its local word line.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int r = 0; r < ROWS; r++) cells[r] <= '0;
            end else if (wr) begin
                for (int r = 0; r < ROWS; r++)
                    if (lwl[r]) cells[r] <= wdata;
            end
        end

        assign group_word[g] = cells[row_idx];

        // R4: a local word line may be active only in the enabled group
        p_lwl_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !grp_en[g] |-> (lwl == '0));
    end

    assign rd_word = group_word[grp_idx];

    // R2: an unselected bank drives no group enable
    p_idle_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> (grp_en == '0));
endmodule

// File: rtl/bsram_counter.sv
// Module: per-bank activity counter. Counts cycles in which its bank is enabled.
// Assumes: wraps at 2**CNT_W.
module bsram_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    output logic [CNT_W-1:0] cnt
);
    // Increment on every enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else if (en) cnt <= cnt + 1'b1;
    end

    // R7: the counter steps by one when enabled and holds otherwise
    p_cnt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (cnt == $past(cnt) + 1'b1));
    p_cnt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(cnt));
endmodule

// File: rtl/banked_sram.sv
// Module: top of the banked memory. Decodes each request, enables one bank
// and one local word-line group, registers read data, and keeps a per-bank
// access count.
// Assumes: BANKS, ROWS, GROUPS are powers of two, each at least 2.
module banked_sram
    import bsram_pkg::*;
#(
    parameter int BANKS  = 4,
    parameter int ROWS   = 8,
    parameter int GROUPS = 4,
    parameter int WIDTH  = 8,
    parameter int CNT_W  = 16,
    localparam int BANK_W = $clog2(BANKS),
    localparam int ROW_W  = $clog2(ROWS),
    localparam int GRP_W  = $clog2(GROUPS),
    localparam int ADDR_W = BANK_W + ROW_W + GRP_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [WIDTH-1:0]       req_wdata,
    output logic [WIDTH-1:0]       rd_data,
    output logic                   rd_valid,
    output logic [BANKS-1:0]       bank_en,
    output logic [GROUPS-1:0]      grp_en,
    output logic [BANKS*CNT_W-1:0] bank_cnt
);
    acc_op_e           op;
    logic [BANK_W-1:0] bank_idx;
    logic [ROW_W-1:0]  row_idx;
    logic [GRP_W-1:0]  grp_idx;
    logic [ROWS-1:0]   row_oh;
    logic [GROUPS-1:0] grp_oh;
    logic [WIDTH-1:0]  bank_rd  [BANKS];
    logic [GROUPS-1:0] bank_grp [BANKS];

    assign op = acc_op_e'(req_write);

    bsram_decode #(.BANKS(BANKS), .ROWS(ROWS), .GROUPS(GROUPS)) u_dec (
        .clk(clk), .rst_n(rst_n), .valid(req_valid), .addr(req_addr),
        .bank_idx(bank_idx), .row_idx(row_idx), .grp_idx(grp_idx),
        .bank_oh(bank_en), .row_oh(row_oh), .grp_oh(grp_oh)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        bsram_bank #(.ROWS(ROWS), .GROUPS(GROUPS), .WIDTH(WIDTH)) u_bank (
            .clk(clk), .rst_n(rst_n), .sel(bank_en[b]),
            .wr(op == ACC_WRITE), .row_oh(row_oh), .grp_oh(grp_oh),
            .row_idx(row_idx), .grp_idx(grp_idx), .wdata(req_wdata),
            .rd_word(bank_rd[b]), .grp_en(bank_grp[b])
        );
        bsram_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .en(bank_en[b]),
            .cnt(bank_cnt[b*CNT_W +: CNT_W])
        );
    end

    // Merge the per-bank group enables; only the selected bank contributes.
    always_comb begin
        grp_en = '0;
        for (int b = 0; b < BANKS; b++) grp_en = grp_en | bank_grp[b];
    end

    // Read pipeline register: capture the addressed word one cycle after a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= req_valid && (op == ACC_READ);
            if (req_valid && op == ACC_READ) rd_data <= bank_rd[bank_idx];
        end
    end

    // R5: a read request yields rd_valid on the next cycle
    p_rd_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid);
    // R6: a write or idle cycle leaves read data held and rd_valid low
    p_rd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> (!rd_valid && $stable(rd_data)));
    // R2: a group enable appears only together with a bank enable
    p_grp_with_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_en != '0) |-> (bank_en != '0));
endmodule

// File: tb/tb_banked_sram.sv
module tb_banked_sram;
    localparam int BANKS = 4, ROWS = 8, GROUPS = 4, WIDTH = 8, CNT_W = 16;
    localparam int ADDR_W = 7;
    localparam int WORDS  = BANKS * ROWS * GROUPS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [WIDTH-1:0]  req_wdata = '0;
    logic [WIDTH-1:0]  rd_data;
    logic              rd_valid;
    logic [BANKS-1:0]  bank_en;
    logic [GROUPS-1:0] grp_en;
    logic [BANKS*CNT_W-1:0] bank_cnt;

    int n_checks = 0, n_fail = 0;
    bit finished = 0;
    int exp_cnt [BANKS];
    logic [WIDTH-1:0] model [WORDS];
    logic [WIDTH-1:0] last_rd;

    always #4 clk = ~clk;

    banked_sram #(.BANKS(BANKS), .ROWS(ROWS), .GROUPS(GROUPS),
                  .WIDTH(WIDTH), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
        .rd_valid(rd_valid), .bank_en(bank_en), .grp_en(grp_en),
        .bank_cnt(bank_cnt)
    );

    task automatic check(string req, string what, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_counters(string req);
        for (int b = 0; b < BANKS; b++)
            check(req, "bank counter", bank_cnt[b*CNT_W +: CNT_W], exp_cnt[b]);
    endtask

    // Called at a falling edge: drives one cycle, checks enables mid-cycle
    // and registered results at the next falling edge.
    task automatic cycle(bit v, bit w, int a, logic [WIDTH-1:0] d);
        int eb, eg;
        req_valid = v; req_write = w; req_addr = a[ADDR_W-1:0]; req_wdata = d;
        eb = a / (ROWS * GROUPS);
        eg = a % GROUPS;
        #1;
        // R1/R3: bank field in the top two address bits
        check("R1", "bank_en", bank_en, v ? (1 << eb) : 0);
        // R2/R3: group field in the bottom two address bits
        check("R2", "grp_en", grp_en, v ? (1 << eg) : 0);
        if (v) begin
            check("R3", "bank field", $clog2(bank_en), eb);
            exp_cnt[eb]++;
            if (w) model[a] = d;
        end
        @(negedge clk);
        if (v && !w) begin
            check("R5", "rd_valid", rd_valid, 1);
            check("R5", "rd_data", rd_data, model[a]);
            last_rd = model[a];
        end else begin
            check("R6", "rd_valid", rd_valid, 0);
            check("R6", "rd_data held", rd_data, last_rd);
        end
    endtask

    function automatic logic [WIDTH-1:0] pat(int a, int k);
        return WIDTH'((a * 37 + k * 11 + 5) & 8'hFF);
    endfunction

    initial begin
        for (int b = 0; b < BANKS; b++) exp_cnt[b] = 0;
        for (int a = 0; a < WORDS; a++) model[a] = '0;
        last_rd = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R8: reset state
        check("R8", "rd_valid", rd_valid, 0);
        check("R8", "rd_data", rd_data, 0);
        check("R1", "bank_en idle", bank_en, 0);
        check("R2", "grp_en idle", grp_en, 0);
        check_counters("R8");
        // R8: every word reads zero after reset
        for (int a = 0; a < WORDS; a++) cycle(1, 0, a, 8'h00);
        check_counters("R7");
        // Fill every word, interleaved with idle cycles.
        for (int a = 0; a < WORDS; a++) begin
            cycle(1, 1, a, pat(a, 0));
            if (a % 16 == 0) cycle(0, 0, 0, 8'h00);
        end
        check_counters("R7");
        // R4: read back in reverse order
        for (int a = WORDS - 1; a >= 0; a--) cycle(1, 0, a, 8'h00);
        // R4: single-word overwrites, each followed by a full sweep
        for (int k = 0; k < 3; k++) begin
            int t;
            t = (k * 45 + 7) % WORDS;
            cycle(1, 1, t, pat(t, k + 1) ^ 8'hA5);
            for (int a = 0; a < WORDS; a++) cycle(1, 0, a, 8'h00);
        end
        // R5: write then read the same word back to back
        cycle(1, 1, 77, 8'h3C);
        cycle(1, 0, 77, 8'h00);
        // R6: write after read leaves the data held
        cycle(1, 1, 12, 8'hC3);
        cycle(0, 0, 0, 8'h00);
        check_counters("R7");
        // R8: mid-run reset clears storage and counters
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int b = 0; b < BANKS; b++) exp_cnt[b] = 0;
        for (int a = 0; a < WORDS; a++) model[a] = '0;
        last_rd = '0;
        check_counters("R8");
        check("R8", "rd_data", rd_data, 0);
        cycle(1, 0, 77, 8'h00);
        cycle(1, 0, 12, 8'h00);
        check_counters("R7");
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule